// File: doc/BRIEF.md
# Packed Byte Rounding Averager

This unit averages two 32-bit words lane by lane. Each word is split into four unsigned 8-bit lanes, and each output lane holds the mean of the two matching input bytes. A third 32-bit word supplies one rounding-control bit per lane, which sits in the lowest bit of that lane's byte. When the bit is set, the lane rounds a half up. When it is clear, the lane truncates. The four lane results are packed back into one 32-bit word.

The default build registers the result. There is one cycle of latency, and a valid flag travels alongside the data. The result register loads only on cycles where the input is flagged valid, so the last result stays on the output between operations. Setting `PIPE_EN` to 0 gives a purely combinational path with the valid flag passed straight through.

The style's state machine does not apply here. There are no named states or transitions. The only sequential element is the output stage: it is either in reset, or it either loads or holds on each clock.

Top module: `byte_avg_unit`

## Requirements
- R1: Lane i uses bits [8i+7:8i] of `op_a`, `op_b` and `avg_q`. No carry or other effect passes from one lane to another, and each lane result lies between its two input bytes inclusive.
- R2: When the lane's rounding bit is 0, the lane result is floor((a+b)/2), with a and b as unsigned bytes.
- R3: When the lane's rounding bit is 1, the lane result is floor((a+b+1)/2), so a half rounds up.
- R4: The rounding bit for lane i is bit 8i of `rnd_sel`. The other seven bits of each `rnd_sel` byte have no effect on any result.
- R5: The lane sum is wide enough that 255+255+1 gives 255, with no wraparound.
- R6: With `PIPE_EN`=1, `avg_q` and `avg_vld` appear one clock after the edge at which `in_vld` is sampled. `avg_vld` is high exactly in the cycles following edges at which `in_vld` was high.
- R7: While `rst_n` is low, `avg_vld` is 0 and `avg_q` is 0.
- R8: On an edge where `in_vld` is low, `avg_q` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input operands are valid this cycle |
| op_a | input | 32 | First packed byte operand |
| op_b | input | 32 | Second packed byte operand |
| rnd_sel | input | 32 | Rounding control; bit 8i controls lane i |
| avg_vld | output | 1 | Result valid |
| avg_q | output | 32 | Packed per-lane averages |

## Verification
Every result is due exactly one clock after the rising edge that captures `in_vld`.

The bench applies operands on a falling edge and reads `avg_q` and `avg_vld` on the next falling edge. Each vector is therefore checked half a cycle after the edge that loads it, and before the next vector can land.

For the hold case, the bench drops `in_vld`, changes the operands, waits a full cycle and confirms that the output did not move. Reset values are read while reset is still asserted.

// File: rtl/byte_avg_pkg.sv
package byte_avg_pkg;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned N_LANES = 4;
    localparam int unsigned WORD_W  = LANE_W * N_LANES;
    localparam int unsigned SUM_W   = LANE_W + 1;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/byte_avg_lane.sv
module byte_avg_lane
    import byte_avg_pkg::*;
(
    input  lane_t a_in,
    input  lane_t b_in,
    input  logic  rnd_up,
    output lane_t mean_out
);
    logic [SUM_W-1:0] lane_sum;

    always_comb begin
        lane_sum = {1'b0, a_in} + {1'b0, b_in} + {{(SUM_W-1){1'b0}}, rnd_up};
        mean_out = lane_sum[SUM_W-1:1];
    end

    always_comb begin
        if (!$isunknown({a_in, b_in, rnd_up})) begin
            // R1
            lane_range_chk: assert ((mean_out >= ((a_in < b_in) ? a_in : b_in)) &&
                                    (mean_out <= ((a_in > b_in) ? a_in : b_in)));
            // R3
            round_up_chk: assert (!rnd_up ||
                ({2'b0, mean_out, 1'b0} >= ({2'b0, a_in} + {2'b0, b_in})));
            // R2
            truncate_chk: assert (rnd_up ||
                ({2'b0, mean_out, 1'b0} <= ({2'b0, a_in} + {2'b0, b_in})));
        end
    end
endmodule

// File: rtl/byte_avg_stage.sv
module byte_avg_stage
    import byte_avg_pkg::*;
#(
    parameter bit PIPE_EN = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vld_in,
    input  word_t data_in,
    output logic  vld_out,
    output word_t data_out
);
    generate
        if (PIPE_EN) begin : g_reg
            logic  vld_r;
            word_t data_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_r  <= 1'b0;
                    data_r <= '0;
                end else begin
                    vld_r <= vld_in;
                    if (vld_in)
                        data_r <= data_in;
                end
            end

            assign vld_out  = vld_r;
            assign data_out = data_r;

            // R6
            vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                vld_in |=> vld_out);
            // R6
            vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !vld_in |=> !vld_out);
            // R8
            hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !vld_in |=> $stable(data_out));
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign vld_out  = vld_in;
            assign data_out = data_in;
        end
    endgenerate
endmodule

// File: rtl/byte_avg_unit.sv
module byte_avg_unit
    import byte_avg_pkg::*;
#(
    parameter bit PIPE_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [31:0] rnd_sel,
    output logic        avg_vld,
    output logic [31:0] avg_q
);
    word_t packed_mean;
    word_t unused_rnd_word;

    assign unused_rnd_word = rnd_sel;

    generate
        for (genvar gi = 0; gi < N_LANES; gi++) begin : g_lane
            byte_avg_lane u_lane (
                .a_in     (op_a[gi*LANE_W +: LANE_W]),
                .b_in     (op_b[gi*LANE_W +: LANE_W]),
                .rnd_up   (rnd_sel[gi*LANE_W]),
                .mean_out (packed_mean[gi*LANE_W +: LANE_W])
            );
        end
    endgenerate

    byte_avg_stage #(.PIPE_EN(PIPE_EN)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_in   (in_vld),
        .data_in  (packed_mean),
        .vld_out  (avg_vld),
        .data_out (avg_q)
    );

    // R5
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (&op_a) && (&op_b)) |=> (&avg_q));
endmodule

// File: tb/byte_avg_unit_bench.sv
module byte_avg_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] rnd_sel = '0;
    logic        avg_vld;
    logic [31:0] avg_q;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    byte_avg_unit u_byte_avg_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .op_a(op_a), .op_b(op_b), .rnd_sel(rnd_sel),
        .avg_vld(avg_vld), .avg_q(avg_q)
    );

    // {a, b, rnd, expected}
    localparam logic [127:0] VEC [9] = '{
        {32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000},
        {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h01010101, 32'hFFFFFFFF},
        {32'h01030507, 32'h00000000, 32'h00000000, 32'h00010203},
        {32'h01030507, 32'h00000000, 32'h01010101, 32'h01020304},
        {32'h01030507, 32'h00000000, 32'hFEFEFEFE, 32'h00010203},
        {32'h01030507, 32'h00000000, 32'h00000100, 32'h00010303},
        {32'hFF00FF00, 32'h01000100, 32'h00000000, 32'h80008000},
        {32'h80FF0102, 32'h7F01FF03, 32'h01000001, 32'h80808003},
        {32'h12345678, 32'h9ABCDEF0, 32'h00000000, 32'h56789AB4}
    };
    string tags [9] = '{"R2", "R5", "R2", "R3", "R4", "R4", "R1", "R3", "R1"};

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset values
        check("R7 vld", {31'b0, avg_vld}, 32'h0);
        check("R7 data", avg_q, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 idle vld", {31'b0, avg_vld}, 32'h0);

        for (int k = 0; k < 9; k++) begin
            op_a    = VEC[k][127:96];
            op_b    = VEC[k][95:64];
            rnd_sel = VEC[k][63:32];
            in_vld  = 1'b1;
            @(negedge clk);
            check(tags[k], avg_q, VEC[k][31:0]);
            check("R6 vld", {31'b0, avg_vld}, 32'h1);
        end

        // R8 hold: in_vld low, new operands ignored
        in_vld  = 1'b0;
        op_a    = 32'h10101010;
        op_b    = 32'h20202020;
        rnd_sel = 32'h01010101;
        @(negedge clk);
        check("R8 hold", avg_q, 32'h56789AB4);
        check("R6 vld drop", {31'b0, avg_vld}, 32'h0);
        @(negedge clk);
        check("R8 hold2", avg_q, 32'h56789AB4);

        // R6 single pulse after gap
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check("R6 pulse data", avg_q, 32'h18181818);
        check("R6 pulse vld", {31'b0, avg_vld}, 32'h1);
        @(negedge clk);
        check("R6 pulse end", {31'b0, avg_vld}, 32'h0);

        // R7 reset mid-run clears output
        rst_n = 1'b0;
        #1;
        check("R7 async data", avg_q, 32'h0);
        check("R7 async vld", {31'b0, avg_vld}, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule